// File: doc/BRIEF.md
# Front-End Reset Sequencer

This block turns the reset inputs of a front-end readout chip into the resets that each part of the chip needs. It has separate inputs for power-up, for the delay-locked loop, for the trigger path, for the event counter and for the bunch-crossing counter, and each one has its own reach. Every asynchronous reset input first passes through a two-stage synchronizer. The synchronizer asserts its output as soon as the input goes low, and it releases the output only on the second clock edge after the input goes high.

The DLL reset output is driven by three sources: the power-up input, a dedicated DLL reset pin and a one-cycle request from the register side. After the last of these sources goes away, the output is held for a further 32 clocks so that the loop can lock. The trigger-level reset clears the readout path: it stops any readout in progress, returns the fast-control machine to idle, sets the pipeline memory pointer and the derandomizer pointers to zero, and throws away every queued trigger. It does not touch either counter. Each counter can only be cleared by its own input or by power-up.

A small readout controller and the two counters are part of the block so that the reach of each reset can be seen at the ports. The pipeline memory pointer advances on every clock. An accepted trigger stores the current pointer value in a four-entry derandomizer. In idle, the fast-control machine takes the oldest stored entry and reads four consecutive memory addresses starting from it.

Top module: `fe_rst_seq`

## Requirements
- R1: After the power-up input goes high, `dll_rst_o` stays high through the 33rd rising clock edge and goes low after the 34th edge. This is 2 edges of synchronization plus 32 edges of extension.
- R2: The dedicated DLL reset input drives `dll_rst_o` high at once, with no clock edge needed. Its release gives the same 2 + 32 edge extension as in R1.
- R3: A one-cycle `sw_dll_req_i` pulse drives `dll_rst_o` high after the edge that samples it. The output then stays high for 31 more edges and goes low after the 32nd edge that follows the sampling edge.
- R4: If a DLL reset input goes low again while the extension count is running, the count restarts. The full 2 + 32 edges are counted again from the new release.
- R5: The first rising edge with the trigger-level reset low drives `rd_active_o` low and sets `mem_ptr_o`, `dr_wr_ptr_o`, `dr_rd_ptr_o` and `pend_o` to zero. Triggers that were queued before the reset are never read out after it is released.
- R6: The trigger-level reset changes neither counter. `bx_cnt_o` keeps counting up by one per clock and `evt_cnt_o` holds its value.
- R7: A low event-reset input clears only `evt_cnt_o` at the next edge. A low BX-reset input clears only `bx_cnt_o` at the next edge.
- R8: `bx_cnt_o` is 12 bits wide and counts up by one on every edge while out of reset, wrapping from 4095 to 0. It reads k-2 on the k-th edge after its reset is released.
- R9: A trigger is accepted when `trig_i` is high, the control path is out of reset and fewer than 4 triggers are pending. `evt_cnt_o` (12 bits, wrapping) counts up by one for each accepted trigger. A trigger that arrives while the derandomizer is full is dropped.
- R10: An accepted trigger sampled at edge E stores the value that `mem_ptr_o` held before E. `mem_ptr_o` is 4 bits wide and counts up by one on every edge. If the machine is idle, after edges E+1 to E+4 `rd_active_o` is high and `rd_addr_o` steps through the stored value plus 0, 1, 2 and 3 (mod 16). After edge E+5 `rd_active_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n_i | input | 1 | Power-up reset, active low, asynchronous; resets the whole block |
| dll_rst_n_i | input | 1 | Dedicated DLL reset pin, active low, asynchronous |
| sw_dll_req_i | input | 1 | One-cycle DLL reset request from the register side, synchronous |
| l0_rst_n_i | input | 1 | Trigger-level reset, active low, asynchronous |
| evt_rst_n_i | input | 1 | Event counter reset, active low, asynchronous |
| bx_rst_n_i | input | 1 | Bunch-crossing counter reset, active low, asynchronous |
| trig_i | input | 1 | Trigger pulse, synchronous |
| dll_rst_o | output | 1 | DLL reset, active high |
| rd_active_o | output | 1 | High while the fast-control machine is reading |
| rd_addr_o | output | 4 | Pipeline memory address being read |
| mem_ptr_o | output | 4 | Pipeline memory write pointer |
| dr_wr_ptr_o | output | 2 | Derandomizer write pointer |
| dr_rd_ptr_o | output | 2 | Derandomizer read pointer |
| pend_o | output | 3 | Number of pending triggers |
| evt_cnt_o | output | 12 | Event counter |
| bx_cnt_o | output | 12 | Bunch-crossing counter |

## Verification
If the extension counter holds a wrong value, `dll_rst_o` falls at the wrong edge within 34 clocks of a release, so the bench checks every edge of each release window. If the trigger-level reset reaches a counter or misses a pointer, the error shows on the very next edge as a counter that jumped or a pointer that is not zero. If the derandomizer holds stale entries, `rd_active_o` goes high again within five clocks of the trigger-level reset being released. If the derandomizer stores a wrong pointer, `rd_addr_o` is off by that amount on the first read cycle.

// File: rtl/fe_rst_pkg.sv
// Package fe_rst_pkg
// Holds the shared constants, the indices into the synchronizer array and
// the state type of the fast-control machine for the reset sequencer.
// Assumes that every depth below is a power of two.
package fe_rst_pkg;

    localparam int DLL_EXT_CYC  = 32;   // clocks the DLL reset is held after release
    localparam int SYNC_STAGES  = 2;    // flops in each reset synchronizer
    localparam int CNT_W        = 12;   // event and BX counter width
    localparam int MEM_DEPTH    = 16;   // pipeline memory depth
    localparam int DR_DEPTH     = 4;    // derandomizer depth
    localparam int READ_LEN     = 4;    // memory words read per trigger

    // positions of the reset inputs in the synchronizer array
    localparam int RIX_POR = 0;
    localparam int RIX_DLL = 1;
    localparam int RIX_L0  = 2;
    localparam int RIX_EVT = 3;
    localparam int RIX_BX  = 4;
    localparam int N_RST   = 5;

    typedef enum logic {
        RDO_IDLE = 1'b0,
        RDO_READ = 1'b1
    } rdo_state_e;

endpackage

// File: rtl/fe_rst_sync.sv
// Module fe_rst_sync
// Reset synchronizer. A low input clears every stage at once, so the output
// asserts without waiting for a clock. A high input shifts a one through
// STAGES flops, so the output releases on the STAGES-th edge after release.
// Assumes STAGES >= 2.
module fe_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n_i,
    output logic srst_n_o
);

    logic [STAGES-1:0] stage_q;

    // shift chain: cleared at once, filled with ones one edge at a time
    always_ff @(posedge clk or negedge arst_n_i) begin
        if (!arst_n_i) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], 1'b1};
        end
    end

    assign srst_n_o = stage_q[STAGES-1];

endmodule

// File: rtl/fe_dll_stretch.sv
// Module fe_dll_stretch
// Drives the DLL reset. The output is high at once while the power-up or the
// dedicated DLL reset (both already synchronized) is low. A synchronous
// request pulse also sets it. After the last source goes away, the output
// stays high for EXT_CYC more edges. Any new source restarts the count.
module fe_dll_stretch #(
    parameter int EXT_CYC = 32
) (
    input  logic clk,
    input  logic por_s_n_i,
    input  logic dll_s_n_i,
    input  logic sw_req_i,
    output logic dll_rst_o
);

    localparam int CW = (EXT_CYC > 1) ? $clog2(EXT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(EXT_CYC - 1);

    logic          hold;
    logic          rst_q;
    logic [CW-1:0] cnt_q;

    assign hold = !por_s_n_i || !dll_s_n_i;

    // extension counter: restarts on any source, clears the output after the last count
    always_ff @(posedge clk) begin
        if (hold || sw_req_i) begin
            rst_q <= 1'b1;
            cnt_q <= '0;
        end else if (rst_q) begin
            if (cnt_q == LAST) begin
                rst_q <= 1'b0;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dll_rst_o = rst_q || hold;

    AST_DLL_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!por_s_n_i)
        (rst_q && cnt_q != LAST) |=> dll_rst_o); // R1
    AST_DLL_RESTART: assert property (@(posedge clk) disable iff (!por_s_n_i)
        (!dll_s_n_i || sw_req_i) |=> (dll_rst_o && cnt_q == '0)); // R4
    AST_DLL_DROP_AT_END: assert property (@(posedge clk) disable iff (!por_s_n_i)
        (rst_q && cnt_q == LAST && dll_s_n_i && !sw_req_i) |=> !rst_q); // R2

endmodule

// File: rtl/fe_wrap_cnt.sv
// Module fe_wrap_cnt
// Counter with a synchronous active-low clear. It counts up by one on
// each cycle with inc_i high and wraps at 2**W.
module fe_wrap_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    // count register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/fe_readout_ctl.sv
// Module fe_readout_ctl
// Fast-control path. A pipeline memory pointer advances on every clock. An
// accepted trigger stores the current pointer in the derandomizer. In idle,
// the machine pops the oldest entry and reads READ_LEN consecutive addresses
// from it. rst_n is the synchronized AND of power-up and trigger-level
// reset; it clears every pointer and every pending trigger.
// Assumes power-of-two depths and READ_LEN >= 2.
module fe_readout_ctl
    import fe_rst_pkg::*;
#(
    parameter int MEM_D  = 16,
    parameter int DR_D   = 4,
    parameter int RD_LEN = 4,
    localparam int MP_W  = $clog2(MEM_D),
    localparam int DR_W  = $clog2(DR_D),
    localparam int PC_W  = DR_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_i,
    output logic            trig_acc_o,
    output logic            rd_active_o,
    output logic [MP_W-1:0] rd_addr_o,
    output logic [MP_W-1:0] mem_ptr_o,
    output logic [DR_W-1:0] dr_wr_ptr_o,
    output logic [DR_W-1:0] dr_rd_ptr_o,
    output logic [PC_W-1:0] pend_o
);

    localparam int WD_W = $clog2(RD_LEN);
    localparam logic [PC_W-1:0] FULL     = PC_W'(DR_D);
    localparam logic [WD_W-1:0] LAST_WRD = WD_W'(RD_LEN - 1);

    rdo_state_e      state_q;
    logic [WD_W-1:0] word_q;
    logic [MP_W-1:0] base_q;
    logic [MP_W-1:0] fifo_q [DR_D];
    logic            push;
    logic            pop;

    assign push       = trig_i && (pend_o != FULL);
    assign pop        = (state_q == RDO_IDLE) && (pend_o != '0);
    assign trig_acc_o = push && rst_n;

    // pipeline memory write pointer, one step per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ptr_o <= '0;
        end else begin
            mem_ptr_o <= mem_ptr_o + 1'b1;
        end
    end

    // derandomizer storage: latch the memory pointer of each accepted trigger
    always_ff @(posedge clk) begin
        if (push) begin
            fifo_q[dr_wr_ptr_o] <= mem_ptr_o;
        end
    end

    // derandomizer pointers and pending count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_wr_ptr_o <= '0;
            dr_rd_ptr_o <= '0;
            pend_o      <= '0;
        end else begin
            if (push) begin
                dr_wr_ptr_o <= dr_wr_ptr_o + 1'b1;
            end
            if (pop) begin
                dr_rd_ptr_o <= dr_rd_ptr_o + 1'b1;
            end
            pend_o <= pend_o + PC_W'(push) - PC_W'(pop);
        end
    end

    // fast-control machine: pop in idle, then walk RD_LEN addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RDO_IDLE;
            word_q  <= '0;
            base_q  <= '0;
        end else begin
            case (state_q)
                RDO_IDLE: begin
                    if (pop) begin
                        base_q  <= fifo_q[dr_rd_ptr_o];
                        word_q  <= '0;
                        state_q <= RDO_READ;
                    end
                end
                RDO_READ: begin
                    word_q <= word_q + 1'b1;
                    if (word_q == LAST_WRD) begin
                        state_q <= RDO_IDLE;
                    end
                end
                default: state_q <= RDO_IDLE;
            endcase
        end
    end

    assign rd_active_o = (state_q == RDO_READ);
    assign rd_addr_o   = rd_active_o ? (base_q + MP_W'(word_q)) : '0;

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o <= FULL); // R9
    AST_FULL_HOLDS_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o == FULL && state_q == RDO_READ) |=> pend_o == FULL); // R9
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active_o && word_q != '0) |-> rd_addr_o == MP_W'($past(rd_addr_o) + 1'b1)); // R10

endmodule

// File: rtl/fe_rst_seq.sv
// Module fe_rst_seq (top)
// Synchronizes the five reset inputs and sends each one only as far as it
// should reach. Power-up resets everything. The DLL pin and the software
// request reach only the DLL reset stretcher. The trigger-level reset
// reaches only the readout path. The event and BX inputs each reach only
// their own counter.
module fe_rst_seq
    import fe_rst_pkg::*;
(
    input  logic        clk,
    input  logic        por_n_i,
    input  logic        dll_rst_n_i,
    input  logic        sw_dll_req_i,
    input  logic        l0_rst_n_i,
    input  logic        evt_rst_n_i,
    input  logic        bx_rst_n_i,
    input  logic        trig_i,
    output logic        dll_rst_o,
    output logic        rd_active_o,
    output logic [3:0]  rd_addr_o,
    output logic [3:0]  mem_ptr_o,
    output logic [1:0]  dr_wr_ptr_o,
    output logic [1:0]  dr_rd_ptr_o,
    output logic [2:0]  pend_o,
    output logic [11:0] evt_cnt_o,
    output logic [11:0] bx_cnt_o
);

    logic [N_RST-1:0] raw_n;
    logic [N_RST-1:0] sync_n;
    logic             ctl_rst_n;
    logic             evt_rst_n;
    logic             bx_rst_n;
    logic             trig_acc;

    assign raw_n[RIX_POR] = por_n_i;
    assign raw_n[RIX_DLL] = dll_rst_n_i;
    assign raw_n[RIX_L0]  = l0_rst_n_i;
    assign raw_n[RIX_EVT] = evt_rst_n_i;
    assign raw_n[RIX_BX]  = bx_rst_n_i;

    // one synchronizer per reset input
    for (genvar i = 0; i < N_RST; i++) begin : g_sync
        fe_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .arst_n_i (raw_n[i]),
            .srst_n_o (sync_n[i])
        );
    end

    // reach of each reset
    assign ctl_rst_n = sync_n[RIX_POR] && sync_n[RIX_L0];
    assign evt_rst_n = sync_n[RIX_POR] && sync_n[RIX_EVT];
    assign bx_rst_n  = sync_n[RIX_POR] && sync_n[RIX_BX];

    fe_dll_stretch #(.EXT_CYC(DLL_EXT_CYC)) u_dll (
        .clk       (clk),
        .por_s_n_i (sync_n[RIX_POR]),
        .dll_s_n_i (sync_n[RIX_DLL]),
        .sw_req_i  (sw_dll_req_i),
        .dll_rst_o (dll_rst_o)
    );

    fe_readout_ctl #(.MEM_D(MEM_DEPTH), .DR_D(DR_DEPTH), .RD_LEN(READ_LEN)) u_rdo (
        .clk         (clk),
        .rst_n       (ctl_rst_n),
        .trig_i      (trig_i),
        .trig_acc_o  (trig_acc),
        .rd_active_o (rd_active_o),
        .rd_addr_o   (rd_addr_o),
        .mem_ptr_o   (mem_ptr_o),
        .dr_wr_ptr_o (dr_wr_ptr_o),
        .dr_rd_ptr_o (dr_rd_ptr_o),
        .pend_o      (pend_o)
    );

    fe_wrap_cnt #(.W(CNT_W)) u_evt_cnt (
        .clk   (clk),
        .rst_n (evt_rst_n),
        .inc_i (trig_acc),
        .cnt_o (evt_cnt_o)
    );

    fe_wrap_cnt #(.W(CNT_W)) u_bx_cnt (
        .clk   (clk),
        .rst_n (bx_rst_n),
        .inc_i (1'b1),
        .cnt_o (bx_cnt_o)
    );

    AST_L0_CLEARS_PATH: assert property (@(posedge clk) disable iff (!sync_n[RIX_POR])
        !sync_n[RIX_L0] |=> (!rd_active_o && pend_o == '0 && mem_ptr_o == '0
                             && dr_wr_ptr_o == '0 && dr_rd_ptr_o == '0)); // R5
    AST_L0_KEEPS_EVT: assert property (@(posedge clk) disable iff (!sync_n[RIX_POR])
        (!sync_n[RIX_L0] && sync_n[RIX_EVT]) |=> evt_cnt_o == $past(evt_cnt_o)); // R6
    AST_L0_KEEPS_BX: assert property (@(posedge clk) disable iff (!sync_n[RIX_POR])
        (!sync_n[RIX_L0] && sync_n[RIX_BX]) |=> bx_cnt_o == 12'($past(bx_cnt_o) + 1'b1)); // R6
    AST_BX_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!sync_n[RIX_POR])
        (!sync_n[RIX_BX] && sync_n[RIX_EVT] && !trig_acc) |=> (bx_cnt_o == '0
                             && evt_cnt_o == $past(evt_cnt_o))); // R7

endmodule

// File: tb/fe_rst_seq_tb.sv
module fe_rst_seq_tb;

    logic        clk = 1'b0;
    logic        por_n_i = 1'b0;
    logic        dll_rst_n_i = 1'b0;
    logic        sw_dll_req_i = 1'b0;
    logic        l0_rst_n_i = 1'b0;
    logic        evt_rst_n_i = 1'b0;
    logic        bx_rst_n_i = 1'b0;
    logic        trig_i = 1'b0;
    logic        dll_rst_o;
    logic        rd_active_o;
    logic [3:0]  rd_addr_o;
    logic [3:0]  mem_ptr_o;
    logic [1:0]  dr_wr_ptr_o;
    logic [1:0]  dr_rd_ptr_o;
    logic [2:0]  pend_o;
    logic [11:0] evt_cnt_o;
    logic [11:0] bx_cnt_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fe_rst_seq u_dut (
        .clk(clk), .por_n_i(por_n_i), .dll_rst_n_i(dll_rst_n_i),
        .sw_dll_req_i(sw_dll_req_i), .l0_rst_n_i(l0_rst_n_i),
        .evt_rst_n_i(evt_rst_n_i), .bx_rst_n_i(bx_rst_n_i), .trig_i(trig_i),
        .dll_rst_o(dll_rst_o), .rd_active_o(rd_active_o), .rd_addr_o(rd_addr_o),
        .mem_ptr_o(mem_ptr_o), .dr_wr_ptr_o(dr_wr_ptr_o), .dr_rd_ptr_o(dr_rd_ptr_o),
        .pend_o(pend_o), .evt_cnt_o(evt_cnt_o), .bx_cnt_o(bx_cnt_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // release window of the DLL reset: high through edge 33, low after edge 34
    task automatic dll_window(input string tag);
        for (int k = 1; k <= 34; k++) begin
            step(1);
            chk(tag, int'(dll_rst_o), (k < 34) ? 1 : 0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int p, e0, b0;
        step(3);
        // reset state
        chk("R1 reset dll", int'(dll_rst_o), 1);
        chk("R8 reset bx", int'(bx_cnt_o), 0);
        chk("R9 reset evt", int'(evt_cnt_o), 0);
        chk("R5 reset pend", int'(pend_o), 0);
        chk("R5 reset active", int'(rd_active_o), 0);

        dll_rst_n_i = 1'b1; l0_rst_n_i = 1'b1; evt_rst_n_i = 1'b1; bx_rst_n_i = 1'b1;
        step(2);
        // R1: power-up release window, edge by edge
        por_n_i = 1'b1;
        dll_window("R1 por release");
        chk("R8 bx after 34 edges", int'(bx_cnt_o), 32);
        step(4096);
        chk("R8 bx wrap", int'(bx_cnt_o), 32);

        // R2: asynchronous assertion and release window of the DLL pin
        dll_rst_n_i = 1'b0;
        #1;
        chk("R2 async assert", int'(dll_rst_o), 1);
        step(2);
        dll_rst_n_i = 1'b1;
        dll_window("R2 dll pin release");

        // R4: restart while counting
        step(2);
        dll_rst_n_i = 1'b0;
        step(1);
        dll_rst_n_i = 1'b1;
        step(20);
        dll_rst_n_i = 1'b0;
        step(1);
        chk("R4 reassert", int'(dll_rst_o), 1);
        dll_rst_n_i = 1'b1;
        dll_window("R4 restart window");

        // R3: software request
        step(3);
        sw_dll_req_i = 1'b1;
        step(1);
        sw_dll_req_i = 1'b0;
        chk("R3 sw set", int'(dll_rst_o), 1);
        for (int k = 1; k <= 32; k++) begin
            step(1);
            chk("R3 sw window", int'(dll_rst_o), (k < 32) ? 1 : 0);
        end

        // R10: single trigger readout
        p = int'(mem_ptr_o);
        e0 = int'(evt_cnt_o);
        trig_i = 1'b1;
        step(1);
        trig_i = 1'b0;
        chk("R10 pend after push", int'(pend_o), 1);
        chk("R9 evt count", int'(evt_cnt_o), e0 + 1);
        for (int w = 0; w < 4; w++) begin
            step(1);
            chk("R10 active", int'(rd_active_o), 1);
            chk("R10 addr", int'(rd_addr_o), (p + w) % 16);
        end
        step(1);
        chk("R10 done", int'(rd_active_o), 0);

        // R9: overflow of the derandomizer
        e0 = int'(evt_cnt_o);
        trig_i = 1'b1;
        step(6);
        trig_i = 1'b0;
        chk("R9 full pend", int'(pend_o), 4);
        chk("R9 dropped trigger", int'(evt_cnt_o), e0 + 5);
        step(40);
        chk("R9 drained", int'(pend_o), 0);
        chk("R9 pointers meet", int'(dr_wr_ptr_o), int'(dr_rd_ptr_o));
        chk("R9 wr ptr", int'(dr_wr_ptr_o), 2);

        // R5 and R6: trigger-level reset during a read with triggers pending
        trig_i = 1'b1;
        step(3);
        trig_i = 1'b0;
        chk("R5 pending before", int'(pend_o), 2);
        chk("R5 active before", int'(rd_active_o), 1);
        b0 = int'(bx_cnt_o);
        e0 = int'(evt_cnt_o);
        l0_rst_n_i = 1'b0;
        trig_i = 1'b1;
        step(1);
        trig_i = 1'b0;
        chk("R5 active cleared", int'(rd_active_o), 0);
        chk("R5 pend cleared", int'(pend_o), 0);
        chk("R5 mem ptr cleared", int'(mem_ptr_o), 0);
        chk("R5 wr ptr cleared", int'(dr_wr_ptr_o), 0);
        chk("R5 rd ptr cleared", int'(dr_rd_ptr_o), 0);
        chk("R6 bx keeps counting", int'(bx_cnt_o), (b0 + 1) % 4096);
        chk("R6 evt kept", int'(evt_cnt_o), e0);
        step(2);
        l0_rst_n_i = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            step(1);
            chk("R5 no stale readout", int'(rd_active_o), 0);
        end
        chk("R5 mem ptr after release", int'(mem_ptr_o), 10);
        chk("R6 evt after release", int'(evt_cnt_o), e0);

        // R7: each counter reset reaches only its own counter
        b0 = int'(bx_cnt_o);
        evt_rst_n_i = 1'b0;
        step(1);
        chk("R7 evt cleared", int'(evt_cnt_o), 0);
        chk("R7 bx untouched", int'(bx_cnt_o), (b0 + 1) % 4096);
        evt_rst_n_i = 1'b1;
        step(3);
        trig_i = 1'b1;
        step(1);
        trig_i = 1'b0;
        e0 = int'(evt_cnt_o);
        chk("R7 evt counts again", e0, 1);
        bx_rst_n_i = 1'b0;
        step(1);
        chk("R7 bx cleared", int'(bx_cnt_o), 0);
        chk("R7 evt untouched", int'(evt_cnt_o), e0);
        bx_rst_n_i = 1'b1;
        step(2);
        chk("R8 bx held through sync", int'(bx_cnt_o), 0);
        step(5);
        chk("R8 bx restarted", int'(bx_cnt_o), 5);

        // R1: power-up reset reaches everything, DLL output at once
        por_n_i = 1'b0;
        #1;
        chk("R1 por async dll", int'(dll_rst_o), 1);
        step(1);
        chk("R1 por clears bx", int'(bx_cnt_o), 0);
        chk("R1 por clears evt", int'(evt_cnt_o), 0);
        chk("R1 por clears mem ptr", int'(mem_ptr_o), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule